// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block serves one fixed window of host physical address space that is spread across several downstream host-bridge ports. Each request carries an offset relative to the window, a direction, a byte count and write data. The block adds the window base to form the host physical address. It picks one port by interleaving at a power-of-two granularity, forwards the access to that port with the full host address, and returns the port's completion to the requester.

Window base, window size, target count and granularity are static configuration inputs. The block checks them continuously and refuses traffic while they are illegal. Some requests cannot be routed: the span falls outside the window, the byte count is out of range, or the selected port is absent. Such reads finish with zero data and an error, and such writes finish quietly with success. Only one request is in flight at a time.

Top module: `fmw_ilv_router`

## Requirements
- R1: `cfg_ok` is low whenever the window size is zero or not a whole multiple of 256 MiB (bits 27:0 nonzero); while `cfg_ok` is low `req_ready` stays low and no request is taken.
- R2: The target count must be 1, 2, 4 or 8 (a power of two no larger than MAX_TGT); any other count, zero included, drives `cfg_ok` low.
- R3: With `cfg_gran_set` low the granularity is 256 bytes whatever `cfg_gran_enc` holds; with it high the granularity is 256 << `cfg_gran_enc` bytes, and an encoding above 6 drives `cfg_ok` low.
- R4: The selected port number is ((base + offset) / granularity) mod target count, taken from the first byte of the access.
- R5: A routed request raises exactly one bit of `dn_valid`, the one at the selected port number, with `dn_addr` = base + offset and the direction, byte count and write data passed unchanged (little-endian lanes untouched).
- R6: A read that cannot be routed (offset + size beyond the window size, size outside 1..8, or selected port absent in `port_present`) raises no `dn_valid` and completes with `rsp_rdata` = 0 and `rsp_err` = 1.
- R7: A write that cannot be routed raises no `dn_valid` and completes with `rsp_err` = 0.
- R8: A routed read returns the selected port's 64-bit `dn_rdata` lane and its `dn_rerr` bit; a routed write returns zero data with that port's `dn_rerr` bit.
- R9: From acceptance until the response handshake `req_ready` is low, and a response held by low `rsp_ready` keeps its data and error bit stable.
- R10: Accesses need no alignment: an unaligned access that crosses an interleave boundary is routed whole to the port of its first byte.
- R11: After reset `rsp_valid` and every `dn_valid` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Host physical address of window start |
| cfg_size | input | ADDR_W | Window size in bytes |
| cfg_ntgt | input | CNT_W | Number of interleave targets |
| cfg_gran_set | input | 1 | Granularity explicitly configured |
| cfg_gran_enc | input | 3 | Granularity encoding, 256 << enc bytes |
| port_present | input | MAX_TGT | Per-port presence mask |
| cfg_ok | output | 1 | Configuration legal |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes |
| req_off | input | ADDR_W | Window-relative offset |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Error / poison indication |
| dn_valid | output | MAX_TGT | Per-port forward strobe |
| dn_ready | input | MAX_TGT | Per-port forward accept |
| dn_addr | output | ADDR_W | Host physical address forwarded |
| dn_wr | output | 1 | Forwarded direction |
| dn_size | output | 4 | Forwarded byte count |
| dn_wdata | output | 64 | Forwarded write data |
| dn_rvalid | input | MAX_TGT | Per-port completion strobe |
| dn_rdata | input | MAX_TGT*64 | Per-port read data lanes |
| dn_rerr | input | MAX_TGT | Per-port completion error |

## Verification
The assertions rely on the configuration inputs staying constant while a request is outstanding, and on a downstream port raising its completion only after it has accepted a forward. The range check on the forwarded port also assumes that `cfg_ntgt` is legal whenever traffic flows. The bench changes configuration only between transactions, after the previous response handshake. Its downstream model answers only the port it was handed, a few cycles after accepting it.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
   localparam int unsigned DATA_W         = 64;
   localparam int unsigned WIN_ALIGN_BITS = 28;
   localparam int unsigned GRAN_BASE_SH   = 8;
   localparam int unsigned GRAN_ENC_MAX   = 6;
   localparam int unsigned MAX_ACC_BYTES  = 8;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FWD,
      ST_WAIT,
      ST_RESP
   } fmw_state_e;
endpackage

// File: rtl/fmw_cfg_check.sv
module fmw_cfg_check #(
   parameter int unsigned ADDR_W  = 48,
   parameter int unsigned MAX_TGT = 8,
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic [CNT_W-1:0]  cfg_ntgt,
   input  logic              cfg_gran_set,
   input  logic [2:0]        cfg_gran_enc,
   output logic              cfg_ok,
   output logic [3:0]        shamt,
   output logic [IDX_W-1:0]  tgt_mask
);
   import fmw_pkg::*;

   logic       size_ok;
   logic       ways_ok;
   logic       gran_ok;
   logic [2:0] enc_eff;

   always_comb begin
      size_ok  = (cfg_size[WIN_ALIGN_BITS-1:0] == '0) && (cfg_size != '0);
      ways_ok  = (cfg_ntgt != '0)
               && ((cfg_ntgt & (cfg_ntgt - 1'b1)) == '0)
               && (cfg_ntgt <= CNT_W'(MAX_TGT));
      gran_ok  = !cfg_gran_set || (cfg_gran_enc <= 3'(GRAN_ENC_MAX));
      enc_eff  = cfg_gran_set ? cfg_gran_enc : 3'd0;
      shamt    = 4'(GRAN_BASE_SH) + {1'b0, enc_eff};
      tgt_mask = IDX_W'(cfg_ntgt - 1'b1);
      cfg_ok   = size_ok && ways_ok && gran_ok;
   end
endmodule

// File: rtl/fmw_addr_decode.sv
module fmw_addr_decode #(
   parameter int unsigned ADDR_W  = 48,
   parameter int unsigned MAX_TGT = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  off,
   input  logic [ADDR_W-1:0]  win_size,
   input  logic [3:0]         acc_size,
   input  logic [3:0]         shamt,
   input  logic [IDX_W-1:0]   tgt_mask,
   input  logic [MAX_TGT-1:0] port_present,
   output logic [ADDR_W-1:0]  host_addr,
   output logic [IDX_W-1:0]   tgt_idx,
   output logic               route_ok
);
   import fmw_pkg::*;

   logic [ADDR_W:0]   end_ext;
   logic [ADDR_W-1:0] shifted;
   logic              in_win;
   logic              size_ok;

   always_comb begin
      host_addr = base + off;
      shifted   = host_addr >> shamt;
      tgt_idx   = shifted[IDX_W-1:0] & tgt_mask;
      end_ext   = {1'b0, off} + {{(ADDR_W-3){1'b0}}, acc_size};
      in_win    = end_ext <= {1'b0, win_size};
      size_ok   = (acc_size != 4'd0) && (acc_size <= 4'(MAX_ACC_BYTES));
      route_ok  = in_win && size_ok && port_present[tgt_idx];
   end
endmodule

// File: rtl/fmw_ilv_router.sv
module fmw_ilv_router #(
   parameter int unsigned ADDR_W  = 48,
   parameter int unsigned MAX_TGT = 8,
   localparam int unsigned CNT_W  = $clog2(MAX_TGT + 1),
   localparam int unsigned IDX_W  = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1,
   localparam int unsigned DW     = fmw_pkg::DATA_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     cfg_base,
   input  logic [ADDR_W-1:0]     cfg_size,
   input  logic [CNT_W-1:0]      cfg_ntgt,
   input  logic                  cfg_gran_set,
   input  logic [2:0]            cfg_gran_enc,
   input  logic [MAX_TGT-1:0]    port_present,
   output logic                  cfg_ok,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_wr,
   input  logic [3:0]            req_size,
   input  logic [ADDR_W-1:0]     req_off,
   input  logic [DW-1:0]         req_wdata,
   output logic                  rsp_valid,
   input  logic                  rsp_ready,
   output logic [DW-1:0]         rsp_rdata,
   output logic                  rsp_err,
   output logic [MAX_TGT-1:0]    dn_valid,
   input  logic [MAX_TGT-1:0]    dn_ready,
   output logic [ADDR_W-1:0]     dn_addr,
   output logic                  dn_wr,
   output logic [3:0]            dn_size,
   output logic [DW-1:0]         dn_wdata,
   input  logic [MAX_TGT-1:0]    dn_rvalid,
   input  logic [MAX_TGT*DW-1:0] dn_rdata,
   input  logic [MAX_TGT-1:0]    dn_rerr
);
   import fmw_pkg::*;

   if (MAX_TGT < 1 || (MAX_TGT & (MAX_TGT - 1)) != 0) begin : g_bad_tgt
      $error("MAX_TGT must be a power of two");
   end
   if (ADDR_W <= WIN_ALIGN_BITS + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for 256 MiB windows");
   end

   logic [3:0]        shamt;
   logic [IDX_W-1:0]  tgt_mask;
   logic [ADDR_W-1:0] host_addr;
   logic [IDX_W-1:0]  tgt_idx;
   logic              route_ok;

   fmw_cfg_check #(
      .ADDR_W (ADDR_W),
      .MAX_TGT(MAX_TGT),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) i_cfg (
      .cfg_size    (cfg_size),
      .cfg_ntgt    (cfg_ntgt),
      .cfg_gran_set(cfg_gran_set),
      .cfg_gran_enc(cfg_gran_enc),
      .cfg_ok      (cfg_ok),
      .shamt       (shamt),
      .tgt_mask    (tgt_mask)
   );

   fmw_addr_decode #(
      .ADDR_W (ADDR_W),
      .MAX_TGT(MAX_TGT),
      .IDX_W  (IDX_W)
   ) i_dec (
      .base        (cfg_base),
      .off         (req_off),
      .win_size    (cfg_size),
      .acc_size    (req_size),
      .shamt       (shamt),
      .tgt_mask    (tgt_mask),
      .port_present(port_present),
      .host_addr   (host_addr),
      .tgt_idx     (tgt_idx),
      .route_ok    (route_ok)
   );

   fmw_state_e        state;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [3:0]        size_q;
   logic [DW-1:0]     wdata_q;
   logic [DW-1:0]     rdata_q;
   logic              err_q;
   logic [DW-1:0]     port_rd [MAX_TGT];
   logic              req_fire;

   for (genvar p = 0; p < MAX_TGT; p++) begin : g_port
      assign dn_valid[p] = (state == ST_FWD) && (idx_q == IDX_W'(p));
      assign port_rd[p]  = dn_rdata[p*DW +: DW];
   end

   assign req_ready = (state == ST_IDLE) && cfg_ok;
   assign req_fire  = req_valid && req_ready;
   assign rsp_valid = (state == ST_RESP);
   assign rsp_rdata = rdata_q;
   assign rsp_err   = err_q;
   assign dn_addr   = addr_q;
   assign dn_wr     = wr_q;
   assign dn_size   = size_q;
   assign dn_wdata  = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx_q   <= '0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         size_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_fire) begin
               addr_q  <= host_addr;
               wr_q    <= req_wr;
               size_q  <= req_size;
               wdata_q <= req_wdata;
               idx_q   <= tgt_idx;
               rdata_q <= '0;
               err_q   <= !route_ok && !req_wr;
               state   <= route_ok ? ST_FWD : ST_RESP;
            end
            ST_FWD: if (dn_ready[idx_q]) state <= ST_WAIT;
            ST_WAIT: if (dn_rvalid[idx_q]) begin
               rdata_q <= wr_q ? '0 : port_rd[idx_q];
               err_q   <= dn_rerr[idx_q];
               state   <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_cfg_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ok |-> !req_ready);
   assert_port_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid != '0) |-> ((dn_valid >> cfg_ntgt) == '0));
   assert_single_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_valid));
   assert_unrouted_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && !route_ok) |=> (dn_valid == '0) && rsp_valid);
   assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || (dn_valid != '0)) |-> !req_ready);
   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
endmodule

// File: tb/test_fmw_ilv_router.sv
module test_fmw_ilv_router;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 48;
   localparam int NT  = 8;
   localparam int CW  = 4;

   typedef struct packed {
      logic          wr;
      logic [3:0]    sz;
      logic [AW-1:0] off;
      logic          fail;
      logic [3:0]    port;
   } vec_t;

   // Config A: base 4 GiB, size 512 MiB, 4 targets, default 256 B granularity
   localparam vec_t VEC [12] = '{
      '{1'b0, 4'd8, 48'h0,         1'b0, 4'd0},
      '{1'b0, 4'd4, 48'h100,       1'b0, 4'd1},
      '{1'b0, 4'd1, 48'h2FF,       1'b0, 4'd2},
      '{1'b0, 4'd8, 48'h3FD,       1'b0, 4'd3},  // R10 crosses into next stripe
      '{1'b0, 4'd2, 48'h400,       1'b0, 4'd0},
      '{1'b0, 4'd8, 48'h1FFF_FFF8, 1'b0, 4'd3},
      '{1'b0, 4'd8, 48'h1FFF_FFF9, 1'b1, 4'd0},
      '{1'b0, 4'd1, 48'h2000_0000, 1'b1, 4'd0},
      '{1'b1, 4'd4, 48'h500,       1'b0, 4'd1},
      '{1'b1, 4'd4, 48'h2000_0000, 1'b1, 4'd0},
      '{1'b0, 4'd0, 48'h10,        1'b1, 4'd0},
      '{1'b0, 4'd9, 48'h10,        1'b1, 4'd0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    cfg_base = 48'h1_0000_0000;
   logic [AW-1:0]    cfg_size = 48'h2000_0000;
   logic [CW-1:0]    cfg_ntgt = 4'd4;
   logic             cfg_gran_set = 1'b0;
   logic [2:0]       cfg_gran_enc = 3'd0;
   logic [NT-1:0]    port_present = '1;
   logic             cfg_ok;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_wr = 1'b0;
   logic [3:0]       req_size = 4'd0;
   logic [AW-1:0]    req_off = '0;
   logic [63:0]      req_wdata = '0;
   logic             rsp_valid;
   logic             rsp_ready = 1'b1;
   logic [63:0]      rsp_rdata;
   logic             rsp_err;
   logic [NT-1:0]    dn_valid;
   logic [NT-1:0]    dn_ready;
   logic [AW-1:0]    dn_addr;
   logic             dn_wr;
   logic [3:0]       dn_size;
   logic [63:0]      dn_wdata;
   logic [NT-1:0]    dn_rvalid;
   logic [NT*64-1:0] dn_rdata;
   logic [NT-1:0]    dn_rerr;
   logic [NT-1:0]    err_inject = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fmw_ilv_router #(.ADDR_W(AW), .MAX_TGT(NT)) i_fmw_ilv_router (
      .clk, .rst_n, .cfg_base, .cfg_size, .cfg_ntgt, .cfg_gran_set, .cfg_gran_enc,
      .port_present, .cfg_ok, .req_valid, .req_ready, .req_wr, .req_size, .req_off,
      .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err, .dn_valid, .dn_ready,
      .dn_addr, .dn_wr, .dn_size, .dn_wdata, .dn_rvalid, .dn_rdata, .dn_rerr
   );

   // Downstream model and monitor
   logic          m_busy;
   logic [2:0]    m_port;
   logic [AW-1:0] m_addr;
   logic [1:0]    m_cnt;
   int            mon_cnt;
   logic [2:0]    mon_port;
   logic [AW-1:0] mon_addr;
   logic          mon_wr;
   logic [3:0]    mon_size;
   logic [63:0]   mon_wdata;

   function automatic logic [2:0] oh_to_idx(input logic [NT-1:0] v);
      logic [2:0] r = '0;
      for (int k = 0; k < NT; k++) if (v[k]) r = 3'(k);
      return r;
   endfunction

   assign dn_ready = '1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_port <= '0; m_addr <= '0; m_cnt <= '0;
         mon_cnt <= 0; mon_port <= '0; mon_addr <= '0; mon_wr <= 1'b0;
         mon_size <= '0; mon_wdata <= '0;
      end else if (!m_busy) begin
         if (dn_valid != '0) begin
            m_busy    <= 1'b1;
            m_port    <= oh_to_idx(dn_valid);
            m_addr    <= dn_addr;
            m_cnt     <= 2'd2;
            mon_cnt   <= mon_cnt + 1;
            mon_port  <= oh_to_idx(dn_valid);
            mon_addr  <= dn_addr;
            mon_wr    <= dn_wr;
            mon_size  <= dn_size;
            mon_wdata <= dn_wdata;
         end
      end else if (m_cnt == 2'd0) begin
         m_busy <= 1'b0;
      end else begin
         m_cnt <= m_cnt - 2'd1;
      end
   end

   always_comb begin
      dn_rvalid = '0;
      dn_rerr   = '0;
      if (m_busy && m_cnt == 2'd0) begin
         dn_rvalid[m_port] = 1'b1;
         dn_rerr[m_port]   = err_inject[m_port];
      end
      for (int p = 0; p < NT; p++) dn_rdata[p*64 +: 64] = {8'(p), 8'hA5, m_addr};
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_req(input logic wr, input logic [3:0] sz, input logic [AW-1:0] off,
                          input logic [63:0] wd, output logic [63:0] rd,
                          output logic er, output int ndn);
      int c0;
      int guard;
      c0 = mon_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_wr = wr; req_size = sz; req_off = off; req_wdata = wd;
      guard = 0;
      while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
      if (!rsp_valid) chk("response timeout", 64'd0, 64'd1);
      rd = rsp_rdata;
      er = rsp_err;
      @(negedge clk);
      ndn = mon_cnt - c0;
   endtask

   task automatic routed_rd(input string tag, input logic [AW-1:0] off, input logic [3:0] port);
      logic [63:0] rd; logic er; int ndn;
      logic [AW-1:0] host;
      host = cfg_base + off;
      run_req(1'b0, 4'd8, off, 64'h0, rd, er, ndn);
      chk({tag, " forward count"}, 64'(ndn), 64'd1);
      chk({tag, " port"}, 64'(mon_port), 64'(port));
      chk({tag, " host addr"}, 64'(rd[47:0]), 64'(host));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] rd; logic er; int ndn; int c0;
      logic [63:0] held;
      logic [AW-1:0] host;
      string tag;

      repeat (3) @(negedge clk);
      chk("R11 rsp_valid in reset", 64'(rsp_valid), 64'd0);
      chk("R11 dn_valid in reset", 64'(dn_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      chk("R11 dn_valid after reset", 64'(dn_valid), 64'd0);
      chk("R1 cfg_ok legal config", 64'(cfg_ok), 64'd1);
      chk("R1 req_ready legal config", 64'(req_ready), 64'd1);

      // Vector table on config A
      for (int i = 0; i < 12; i++) begin
         host = cfg_base + VEC[i].off;
         run_req(VEC[i].wr, VEC[i].sz, VEC[i].off, {16'hC0DE, VEC[i].off}, rd, er, ndn);
         if (VEC[i].fail) begin
            tag = VEC[i].wr ? "R7" : "R6";
            chk({tag, " no forward"}, 64'(ndn), 64'd0);
            chk({tag, " err"}, 64'(er), 64'(!VEC[i].wr));
            if (!VEC[i].wr) chk("R6 zero data", rd, 64'd0);
         end else begin
            tag = (i == 3) ? "R10" : "R4";
            chk({tag, " forward count"}, 64'(ndn), 64'd1);
            chk({tag, " port"}, 64'(mon_port), 64'(VEC[i].port));
            chk("R5 host addr", 64'(mon_addr), 64'(host));
            chk("R5 size", 64'(mon_size), 64'(VEC[i].sz));
            chk("R5 dir", 64'(mon_wr), 64'(VEC[i].wr));
            chk("R8 err", 64'(er), 64'd0);
            if (VEC[i].wr) begin
               chk("R5 wdata", mon_wdata, {16'hC0DE, VEC[i].off});
               chk("R8 write data zero", rd, 64'd0);
            end else begin
               chk("R8 read data", rd, {8'(VEC[i].port), 8'hA5, host});
            end
         end
      end

      // Config B: unaligned base, 8 targets, 1 KiB granularity
      cfg_base = 48'h4000_0100; cfg_size = 48'h1000_0000; cfg_ntgt = 4'd8;
      cfg_gran_set = 1'b1; cfg_gran_enc = 3'd2;
      routed_rd("R4 base+gran", 48'h0, 4'd0);
      routed_rd("R4 base+gran", 48'h300, 4'd1);
      routed_rd("R4 base+gran", 48'h1B00, 4'd7);
      routed_rd("R4 base+gran", 48'h1F00, 4'd0);

      // Config C: granularity encoding ignored when not set
      cfg_base = 48'h1_0000_0000; cfg_size = 48'h2000_0000; cfg_ntgt = 4'd2;
      cfg_gran_set = 1'b0; cfg_gran_enc = 3'd5;
      routed_rd("R3 default gran", 48'h100, 4'd1);
      routed_rd("R3 default gran", 48'h200, 4'd0);

      // Absent port: config A with port 1 missing
      cfg_ntgt = 4'd4; port_present = 8'hFD;
      run_req(1'b0, 4'd4, 48'h100, 64'h0, rd, er, ndn);
      chk("R6 absent port no forward", 64'(ndn), 64'd0);
      chk("R6 absent port err", 64'(er), 64'd1);
      chk("R6 absent port data", rd, 64'd0);
      run_req(1'b1, 4'd4, 48'h100, 64'h1234, rd, er, ndn);
      chk("R7 absent port no forward", 64'(ndn), 64'd0);
      chk("R7 absent port err", 64'(er), 64'd0);
      port_present = '1;

      // Downstream error passes through
      err_inject = 8'h04;
      run_req(1'b0, 4'd8, 48'h200, 64'h0, rd, er, ndn);
      chk("R8 downstream err", 64'(er), 64'd1);
      chk("R8 downstream err data", 64'(rd[63:56]), 64'd2);
      err_inject = '0;

      // Response held: one outstanding, stable response
      rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_wr = 1'b0; req_size = 4'd8; req_off = 48'h300;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      held = rsp_rdata;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R9 req_ready low while busy", 64'(req_ready), 64'd0);
         chk("R9 rsp held valid", 64'(rsp_valid), 64'd1);
         chk("R9 rsp data stable", rsp_rdata, held);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R9 ready after handshake", 64'(req_ready), 64'd1);

      // Illegal configurations
      cfg_size = 48'h1000_0001; #1;
      chk("R1 size not multiple", 64'(cfg_ok), 64'd0);
      chk("R1 ready gated", 64'(req_ready), 64'd0);
      cfg_size = 48'h0; #1;
      chk("R1 zero size", 64'(cfg_ok), 64'd0);
      cfg_size = 48'h3000_0000; cfg_ntgt = 4'd3; #1;
      chk("R2 count three", 64'(cfg_ok), 64'd0);
      cfg_ntgt = 4'd0; #1;
      chk("R2 count zero", 64'(cfg_ok), 64'd0);
      cfg_ntgt = 4'd8; #1;
      chk("R2 count eight", 64'(cfg_ok), 64'd1);
      cfg_gran_set = 1'b1; cfg_gran_enc = 3'd7; #1;
      chk("R3 enc seven", 64'(cfg_ok), 64'd0);
      cfg_gran_enc = 3'd6; #1;
      chk("R3 enc six", 64'(cfg_ok), 64'd1);

      // Traffic refused under a bad size
      cfg_size = 48'h1000_0001;
      c0 = mon_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_off = 48'h0;
      repeat (5) @(negedge clk);
      chk("R1 no response when invalid", 64'(rsp_valid), 64'd0);
      chk("R1 no forward when invalid", 64'(mon_cnt - c0), 64'd0);
      req_valid = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule